// File: doc/BRIEF.md
# L0-to-L1 Trigger Latency Checker

The block runs on the bunch-crossing clock and watches two trigger strobes, L0 and L1. When L0 support is enabled, an L0 opens a timing window. The block then classifies the next L1 by its distance from that L0, measured in clock cycles. The expected distance is a 12-bit latency. Around it lies a symmetric uncertainty region of ±N cycles, where N is a 4-bit value. An L1 that lands outside the region is flagged. So is an L0 that arrives while a window is already open. The block also flags an L1 that has no L0 in front of it, and an L0 that is never followed by an L1.

Each result appears as a one-cycle pulse, registered one cycle after the cycle that caused it. Two 16-bit counters record how many L0 and L1 strobes have been seen, and a synchronous clear input zeroes them. A free-running 12-bit bunch-crossing count is sampled each time an L1 arrives, so the L1 can be placed within the orbit.

The distance d of an L1 is the number of clock cycles since the cycle in which the L0 opened the window. L and N below are the latency and tolerance inputs. The flag outputs are one-cycle pulses that appear in the cycle after the strobe or expiry that causes them.

Top module: `trig_latency_chk`

## Requirements
- R1: With L0 support on and a window open, an L1 at a distance d with max(L-N,0) <= d <= L+N pulses `l1_ok_o` and closes the window.
- R2: With L0 support on and a window open, an L1 at d = L+N+1 pulses `err_boundary_l1_o` and closes the window. So does an L1 at d = L-N-1, but only when L > N.
- R3: If a window is still open at d = L+N+1 and no L1 arrives in that cycle, `err_missing_l1_o` pulses and the window closes.
- R4: With a window open, an L1 at a distance that fits neither R1 nor R2 pulses `err_spurious_l1_o` and leaves the window open, with its timing unchanged.
- R5: With L0 support on and no window open, an L1 pulses both `err_spurious_l1_o` and `err_missing_l0_o`. An L1 in the same cycle as the L0 that opens a window counts as having no window open.
- R6: An L0 that arrives while a window is open pulses `err_spurious_l0_o`. It does not restart the window's timing. This includes the cycle in which the window closes.
- R7: With L0 support off, no window opens, every L1 pulses `l1_ok_o`, and no error flag is raised.
- R8: `l0_cnt_o` and `l1_cnt_o` count every strobe on their input, whatever the L0 support setting, and wrap modulo 2^16. `cnt_clr_i` zeroes both at the next edge and takes priority over a strobe in the same cycle.
- R9: A 12-bit bunch-crossing count starts at 0 after reset and increments every cycle. In the cycle after an L1, `bc_at_l1_o` holds the value the count had in the L1 cycle, and it keeps that value until the next L1.
- R10: After reset, all flags, both counters and `bc_at_l1_o` are 0, and no window is open.
- R11: In any one cycle, at most one of `l1_ok_o`, `err_boundary_l1_o`, `err_spurious_l1_o` and `err_missing_l1_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l0_i | input | 1 | L0 trigger strobe |
| l1_i | input | 1 | L1 trigger strobe |
| l0_en_i | input | 1 | L0 support enable; when high, L0 triggers are expected |
| latency_i | input | 12 | Expected L0-to-L1 distance, in cycles |
| tol_i | input | 4 | Uncertainty half-width N, in cycles |
| cnt_clr_i | input | 1 | Synchronous clear for both trigger counters |
| l1_ok_o | output | 1 | Pulse: the L1 was accepted |
| err_spurious_l0_o | output | 1 | Pulse: an L0 arrived while a window was open |
| err_missing_l0_o | output | 1 | Pulse: an L1 arrived with no preceding L0 |
| err_spurious_l1_o | output | 1 | Pulse: the L1 fell outside any acceptable slot |
| err_boundary_l1_o | output | 1 | Pulse: the L1 fell one cycle outside the region |
| err_missing_l1_o | output | 1 | Pulse: the window expired without an L1 |
| l0_cnt_o | output | 16 | L0 strobe count |
| l1_cnt_o | output | 16 | L1 strobe count |
| bc_at_l1_o | output | 12 | Bunch-crossing count captured at the last L1 |

## Verification
Some properties hold on every cycle, and the assertions check them there. At most one L1 class is raised per cycle. A missing-L0 flag always comes with a spurious-L1 flag. An accepted or boundary L1 closes the window, and a spurious L0 leaves the window age running. The counters clear and step correctly, and the captured bunch-crossing value holds between L1s.

Other behaviour depends on where an L1 lands relative to the latency and tolerance, and only the bench scenarios can show it. The bench sweeps the L1 distance over every cycle from before the window up to past its expiry, for several latency and tolerance pairs. These include a latency smaller than the tolerance, which clamps the lower bound to zero. The bench also exercises the default setting, a 16-bit counter wrap, and the absolute captured count.

// File: rtl/trig_lat_pkg.sv
package trig_lat_pkg;
  typedef struct packed {
    logic ok;
    logic sp_l0;
    logic miss_l0;
    logic sp_l1;
    logic bnd_l1;
    logic miss_l1;
  } trig_evt_t;
endpackage

// File: rtl/lat_window.sv
module lat_window
  import trig_lat_pkg::*;
#(
  parameter int LAT_W = 12,
  parameter int TOL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l0_i,
  input  logic             l1_i,
  input  logic             l0_en_i,
  input  logic [LAT_W-1:0] latency_i,
  input  logic [TOL_W-1:0] tol_i,
  output trig_evt_t        evt_o
);
  localparam int AW = LAT_W + 1;

  logic          pend_q;
  logic [AW-1:0] age_q;
  logic [AW-1:0] lat_x, hi, hi1, lo, lo_b;
  logic          lo_b_ok, in_win, at_edge, expire, close;
  trig_evt_t     evt_d, evt_q;

  always_comb begin
    lat_x   = {1'b0, latency_i};
    hi      = lat_x + AW'(tol_i);
    hi1     = hi + AW'(1);
    lo      = (lat_x >= AW'(tol_i)) ? lat_x - AW'(tol_i) : '0;
    lo_b_ok = lat_x > AW'(tol_i);
    lo_b    = lat_x - AW'(tol_i) - AW'(1);
    in_win  = pend_q && (age_q >= lo) && (age_q <= hi);
    at_edge = pend_q && ((age_q == hi1) || (lo_b_ok && (age_q == lo_b)));
    expire  = pend_q && (age_q >= hi1);
    close   = l0_en_i && pend_q && ((l1_i && (in_win || at_edge)) || expire);
  end

  always_comb begin
    evt_d = '0;
    if (l1_i) begin
      if (!l0_en_i)     evt_d.ok = 1'b1;
      else if (in_win)  evt_d.ok = 1'b1;
      else if (at_edge) evt_d.bnd_l1 = 1'b1;
      else if (pend_q)  evt_d.sp_l1 = 1'b1;
      else begin
        evt_d.sp_l1   = 1'b1;
        evt_d.miss_l0 = 1'b1;
      end
    end
    if (l0_en_i && expire && !l1_i) evt_d.miss_l1 = 1'b1;
    if (l0_en_i && l0_i && pend_q)  evt_d.sp_l0 = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      age_q  <= '0;
      evt_q  <= '0;
    end else begin
      evt_q <= evt_d;
      if (!l0_en_i) begin
        pend_q <= 1'b0;
        age_q  <= '0;
      end else if (close) begin
        pend_q <= 1'b0;
        age_q  <= '0;
      end else if (pend_q) begin
        age_q <= age_q + AW'(1);
      end else if (l0_i) begin
        pend_q <= 1'b1;
        age_q  <= AW'(1);
      end
    end
  end

  assign evt_o = evt_q;

  a_r11_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_q.ok, evt_q.bnd_l1, evt_q.sp_l1, evt_q.miss_l1}));

  a_r5_missing_l0_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q.miss_l0 |-> evt_q.sp_l1);

  a_r1_accept_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l0_en_i && l1_i && in_win) |=> !pend_q);

  a_r6_sp_l0_keeps_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l0_en_i && l0_i && pend_q && !close) |=> (pend_q && age_q == $past(age_q) + AW'(1)));

  a_r7_no_window_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l0_en_i |=> !pend_q);
endmodule

// File: rtl/trig_cnt.sv
module trig_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/bc_capture.sv
module bc_capture #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         l1_i,
  output logic [W-1:0] bc_at_o
);
  logic [W-1:0] bc_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_q  <= '0;
      cap_q <= '0;
    end else begin
      bc_q <= bc_q + W'(1);
      if (l1_i) cap_q <= bc_q;
    end
  end

  assign bc_at_o = cap_q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l1_i |=> $stable(bc_at_o));

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_i |=> (bc_at_o == $past(bc_q)));
endmodule

// File: rtl/trig_latency_chk.sv
module trig_latency_chk
  import trig_lat_pkg::*;
#(
  parameter int LAT_W = 12,
  parameter int TOL_W = 4,
  parameter int CNT_W = 16,
  parameter int BC_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l0_i,
  input  logic             l1_i,
  input  logic             l0_en_i,
  input  logic [LAT_W-1:0] latency_i,
  input  logic [TOL_W-1:0] tol_i,
  input  logic             cnt_clr_i,
  output logic             l1_ok_o,
  output logic             err_spurious_l0_o,
  output logic             err_missing_l0_o,
  output logic             err_spurious_l1_o,
  output logic             err_boundary_l1_o,
  output logic             err_missing_l1_o,
  output logic [CNT_W-1:0] l0_cnt_o,
  output logic [CNT_W-1:0] l1_cnt_o,
  output logic [BC_W-1:0]  bc_at_l1_o
);
  localparam int NSTR = 2;

  trig_evt_t        evt;
  logic [NSTR-1:0]  strobe;
  logic [CNT_W-1:0] cnt [NSTR];

  lat_window #(.LAT_W(LAT_W), .TOL_W(TOL_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .l0_i      (l0_i),
    .l1_i      (l1_i),
    .l0_en_i   (l0_en_i),
    .latency_i (latency_i),
    .tol_i     (tol_i),
    .evt_o     (evt)
  );

  assign strobe = {l1_i, l0_i};

  for (genvar g = 0; g < NSTR; g++) begin : g_cnt
    trig_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr_i),
      .inc_i  (strobe[g]),
      .cnt_o  (cnt[g])
    );
  end

  bc_capture #(.W(BC_W)) u_bc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .l1_i    (l1_i),
    .bc_at_o (bc_at_l1_o)
  );

  assign l1_ok_o           = evt.ok;
  assign err_spurious_l0_o = evt.sp_l0;
  assign err_missing_l0_o  = evt.miss_l0;
  assign err_spurious_l1_o = evt.sp_l1;
  assign err_boundary_l1_o = evt.bnd_l1;
  assign err_missing_l1_o  = evt.miss_l1;
  assign l0_cnt_o          = cnt[0];
  assign l1_cnt_o          = cnt[1];
endmodule

// File: tb/trig_latency_chk_bench.sv
module trig_latency_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l0 = 1'b0, l1 = 1'b0, l0_en = 1'b1, clr = 1'b0;
  logic [11:0] lat = 12'd4;
  logic [3:0]  tol = 4'd1;
  logic        ok, sp0, ms0, sp1, bn1, ms1;
  logic [15:0] c0, c1;
  logic [11:0] bc;
  logic [5:0]  obs;
  logic [15:0] m0 = '0, m1 = '0;
  int          n_chk = 0, n_fail = 0, edges = 0;
  bit          done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  trig_latency_chk u_trig_latency_chk (
    .clk_i(clk), .rst_ni(rst_n), .l0_i(l0), .l1_i(l1), .l0_en_i(l0_en),
    .latency_i(lat), .tol_i(tol), .cnt_clr_i(clr),
    .l1_ok_o(ok), .err_spurious_l0_o(sp0), .err_missing_l0_o(ms0),
    .err_spurious_l1_o(sp1), .err_boundary_l1_o(bn1), .err_missing_l1_o(ms1),
    .l0_cnt_o(c0), .l1_cnt_o(c1), .bc_at_l1_o(bc));

  // [5]ok [4]sp_l0 [3]miss_l0 [2]sp_l1 [1]bnd_l1 [0]miss_l1
  assign obs = {ok, sp0, ms0, sp1, bn1, ms1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input logic [5:0] e, input bit do_chk);
    l0 = a; l1 = b;
    if (clr) begin m0 = '0; m1 = '0; end
    else begin if (a) m0 = m0 + 16'd1; if (b) m1 = m1 + 16'd1; end
    @(posedge clk); @(negedge clk);
    if (do_chk) chk("R1 R2 R3 R4 R5 R6 R11 event", {26'd0, obs}, {26'd0, e});
  endtask

  function automatic logic [5:0] exp_at(int L, int n, int d, int s, int k);
    int hi = L + n;
    int lo = (L >= n) ? L - n : 0;
    int blo = (L > n) ? L - n - 1 : -1;
    bit acc = (d >= 1) && (d >= lo) && (d <= hi);
    bit bnd = (d >= 1) && ((d == hi + 1) || (d == blo));
    int endc = (acc || bnd) ? d : hi + 1;
    bit open = (k >= 1) && (k <= endc);
    logic [5:0] r = '0;
    if (k == d) begin
      if (!open) r[3:2] = 2'b11;
      else if (acc) r[5] = 1'b1;
      else if (bnd) r[1] = 1'b1;
      else r[2] = 1'b1;
    end
    if (k == hi + 1 && open && d != k) r[0] = 1'b1;
    if (s != 0 && k == s && open) r[4] = 1'b1;
    return r;
  endfunction

  task automatic trial(input int L, input int n, input int d, input int s);
    lat = 12'(L); tol = 4'(n);
    for (int k = 0; k <= L + n + 3; k++)
      cyc(k == 0 || k == s, k == d, exp_at(L, n, d, s, k), 1);
    cyc(0, 0, 6'd0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp_bc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 flags", {26'd0, obs}, 32'd0);
    chk("R10 l0 count", {16'd0, c0}, 32'd0);
    chk("R10 l1 count", {16'd0, c1}, 32'd0);
    chk("R10 bc", {20'd0, bc}, 32'd0);
    rst_n = 1'b1;
    cyc(0, 0, 6'd0, 1);

    // R1 R2 R3 R4 sweep of L1 distance, including lower bound clamp (L < N)
    foreach (lat_set[i]) ;
    for (int li = 0; li < 4; li++)
      for (int ni = 0; ni < 3; ni++) begin
        int L = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 4 : 6;
        int n = (ni == 0) ? 0 : (ni == 1) ? 1 : 3;
        for (int d = 0; d <= L + n + 3; d++) trial(L, n, d, 0);
      end

    // R6 spurious L0 inside the window, with and without an accepted L1
    for (int s = 1; s <= 6; s++) trial(5, 1, 0, s);
    for (int s = 1; s <= 5; s++) trial(5, 1, 5, s);

    // R1 R2 R3 at the default setting
    trial(212, 2, 210, 0);
    trial(212, 2, 214, 0);
    trial(212, 2, 209, 0);
    trial(212, 2, 215, 0);
    trial(212, 2, 0, 0);

    // R5 isolated L1; R9 capture against bench cycle count
    cyc(0, 1, 6'b001100, 1);
    exp_bc = 12'(edges - 1);
    chk("R9 capture", {20'd0, bc}, {20'd0, exp_bc});
    repeat (5) cyc(0, 0, 6'd0, 1);
    chk("R9 hold", {20'd0, bc}, {20'd0, exp_bc});

    // R7 L0 support off
    l0_en = 1'b0; lat = 12'd3; tol = 4'd0;
    cyc(1, 0, 6'd0, 1);
    cyc(0, 0, 6'd0, 1);
    cyc(0, 0, 6'd0, 1);
    cyc(0, 1, 6'b100000, 1);
    repeat (5) cyc(0, 0, 6'd0, 1);
    cyc(0, 1, 6'b100000, 1);

    // R8 counts so far
    cyc(0, 0, 6'd0, 1);
    chk("R8 l0 count", {16'd0, c0}, {16'd0, m0});
    chk("R8 l1 count", {16'd0, c1}, {16'd0, m1});

    // R8 clear wins over strobes
    clr = 1'b1; cyc(1, 1, 6'b100000, 1); clr = 1'b0;
    chk("R8 clear l0", {16'd0, c0}, 32'd0);
    chk("R8 clear l1", {16'd0, c1}, 32'd0);

    // R8 wrap at 16 bits, R9 absolute capture after a long run
    for (int i = 0; i < 65538; i++) cyc(1, 1, 6'd0, 0);
    chk("R8 wrap l0", {16'd0, c0}, 32'd2);
    chk("R8 wrap l1", {16'd0, c1}, 32'd2);
    exp_bc = 12'(edges - 1);
    chk("R9 capture after run", {20'd0, bc}, {20'd0, exp_bc});
    cyc(0, 0, 6'd0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int lat_set[1];
endmodule